// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This peripheral keeps time as a count of seconds. Two 32-bit counters advance together on a one-second tick input. One counts upward from zero and the other counts downward from all ones, so software that loads them as complements sees them always sum to all ones. Two match registers are compared against the up counter. A hit on either one sets a sticky status bit. A status bit drives the interrupt output when its enable bit in the control register is set.

Software reaches the block through a simple single-cycle bus. Writes take effect at the clock edge, and read data is combinational from the address. The control register has two bits that govern counting. One is a hold bit, which freezes both counters while new counts are loaded. The other is a soft-clear bit, which forces the counters back to their reset values. A free-form key register lets software leave a marker, such as 0xB5C13F27, that shows setup has already been done.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the up count reads 0, the down count reads 0xFFFFFFFF, both match registers read 0xFFFFFFFF, and control, status and key read 0. The interrupt output is low.
- R2: With control bits 4 and 6 clear, each clock with the tick input high increments the up count and decrements the down count, each by one. Without a tick, neither counter changes.
- R3: While control bit 6 (hold) is set, ticks do not change either counter, but bus writes to the counters still load them.
- R4: Both counters wrap modulo 2^32. The up count steps from 0xFFFFFFFF to 0, and the down count steps from 0 to 0xFFFFFFFF.
- R5: A bus write to a counter in the same cycle as a tick loads the written value. A counter that is not written in that cycle still takes the tick.
- R6: Status bit n (bit 0 for match register 0, bit 1 for match register 1) is set at the clock edge after the up count equals match register n. This happens whether or not that interrupt is enabled.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. While the up count still equals the match value, the bit is set again and a clear does not take effect.
- R8: The interrupt output is high exactly when some status bit n is set together with control bit n (bit 0 enables match 0, bit 1 enables match 1).
- R9: While control bit 4 (soft clear) is set, the up count is forced to 0 and the down count to 0xFFFFFFFF, one edge after the bit is seen. Ticks and counter writes are ignored during that time.
- R10: The key register stores and returns any 32-bit value written to it, including 0xB5C13F27.
- R11: Reads from offsets outside the map return 0, and writes to them change no register. Control reads back bits 7:0 with bit 5 forced to 0. Status reads back only bits 1:0.
- R12: Byte offsets are: up count 0x00, down count 0x04, match 0 0x08, match 1 0x0C, control 0x10, status 0x14, key 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one clock wide |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 8 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt, enabled status bits OR-ed |

## Verification
The hardest case to reach is a status bit that is being cleared while its comparison is still true. That needs the up count parked exactly on the match value while software writes to the status register. The stimulus uses the hold bit to load the up count two below the match value. It then releases the hold, sends exactly two ticks, and issues clears while no further tick arrives. The same parking technique exposes the wrap at all ones, where the default match value also fires. The counter-write against tick race is produced by driving a write strobe and a tick in the same cycle.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;

  localparam int SA_DW     = 32;
  localparam int SA_AW     = 8;
  localparam int SA_NMATCH = 2;
  localparam int SA_CTRL_W = 8;

  // byte offsets of the register map
  localparam logic [SA_AW-1:0] OFS_UP    = 8'h00;
  localparam logic [SA_AW-1:0] OFS_DOWN  = 8'h04;
  localparam logic [SA_AW-1:0] OFS_MATCH = 8'h08;  // match n at OFS_MATCH + 4*n
  localparam logic [SA_AW-1:0] OFS_CTRL  = 8'h10;
  localparam logic [SA_AW-1:0] OFS_STAT  = 8'h14;
  localparam logic [SA_AW-1:0] OFS_KEY   = 8'h18;

  // control bit positions
  localparam int CB_SOFT_CLR = 4;
  localparam int CB_HOLD     = 6;
  localparam logic [SA_CTRL_W-1:0] CTRL_KEEP = 8'hDF;

  function automatic logic [SA_DW-1:0] step_count(input logic [SA_DW-1:0] v,
                                                  input logic upward);
    return upward ? v + 1'b1 : v - 1'b1;
  endfunction

  function automatic logic [SA_AW-1:0] match_ofs(input int n);
    return OFS_MATCH + SA_AW'(4 * n);
  endfunction

endpackage

// File: rtl/sec_counter.sv
module sec_counter
  import sec_alarm_pkg::*;
#(
  parameter int W          = 32,
  parameter bit COUNT_UP   = 1'b1,
  parameter bit INIT_ONES  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         force_init,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q
);

  localparam logic [W-1:0] INIT_VAL = {W{INIT_ONES}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_q <= INIT_VAL;
    else if (force_init) count_q <= INIT_VAL;
    else if (load)       count_q <= load_val;
    else if (step)       count_q <= W'(step_count(SA_DW'(count_q), COUNT_UP));
  end

endmodule

// File: rtl/sec_match_bank.sv
module sec_match_bank #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        count,
  input  logic [N-1:0]        wr_match,
  input  logic [W-1:0]        wdata,
  input  logic [N-1:0]        clr_mask,
  output logic [N-1:0][W-1:0] match_q,
  output logic [N-1:0]        hit,
  output logic [N-1:0]        stat_q
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           match_q[g] <= '1;
        else if (wr_match[g]) match_q[g] <= wdata;
      end

      assign hit[g] = (count == match_q[g]);

      // a live comparison wins over a clear request
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[g] <= 1'b0;
        else        stat_q[g] <= hit[g] | (stat_q[g] & ~clr_mask[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sec_alarm_pkg::*;
#(
  parameter int DATA_W = SA_DW,
  parameter int ADDR_W = SA_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int NM = SA_NMATCH;

  logic [SA_CTRL_W-1:0]    ctrl_q;
  logic [DATA_W-1:0]       key_q;
  logic [1:0][DATA_W-1:0]  cnt_q;
  logic [1:0]              cnt_load;
  logic [DATA_W-1:0]       up_q;
  logic [DATA_W-1:0]       dn_q;
  logic [NM-1:0][DATA_W-1:0] match_q;
  logic [NM-1:0]           match_evt;
  logic [NM-1:0]           stat_q;
  logic [NM-1:0]           wr_match;
  logic [NM-1:0]           stat_clr;
  logic                    hold_cnt;
  logic                    soft_clr;
  logic                    cnt_step;
  logic                    wr_ctrl;
  logic                    wr_key;
  logic                    wr_stat;

  // ---------------- write decode ----------------
  assign cnt_load[0] = wr_en_i && (addr_i == ADDR_W'(OFS_UP));
  assign cnt_load[1] = wr_en_i && (addr_i == ADDR_W'(OFS_DOWN));
  assign wr_ctrl     = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_stat     = wr_en_i && (addr_i == ADDR_W'(OFS_STAT));
  assign wr_key      = wr_en_i && (addr_i == ADDR_W'(OFS_KEY));

  genvar m;
  generate
    for (m = 0; m < NM; m++) begin : g_mdec
      assign wr_match[m] = wr_en_i && (addr_i == ADDR_W'(match_ofs(m)));
    end
  endgenerate

  assign stat_clr = wr_stat ? wdata_i[NM-1:0] : '0;

  // ---------------- control and key ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata_i[SA_CTRL_W-1:0] & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (wr_key) key_q <= wdata_i;
  end

  assign hold_cnt = ctrl_q[CB_HOLD];
  assign soft_clr = ctrl_q[CB_SOFT_CLR];
  assign cnt_step = tick_i && !hold_cnt;

  // ---------------- counter pair ----------------
  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : g_cnt
      sec_counter #(
        .W         (DATA_W),
        .COUNT_UP  (c == 0),
        .INIT_ONES (c != 0)
      ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (cnt_step),
        .force_init (soft_clr),
        .load       (cnt_load[c]),
        .load_val   (wdata_i),
        .count_q    (cnt_q[c])
      );
    end
  endgenerate

  assign up_q = cnt_q[0];
  assign dn_q = cnt_q[1];

  // ---------------- comparators and status ----------------
  sec_match_bank #(
    .W (DATA_W),
    .N (NM)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (up_q),
    .wr_match (wr_match),
    .wdata    (wdata_i),
    .clr_mask (stat_clr),
    .match_q  (match_q),
    .hit      (match_evt),
    .stat_q   (stat_q)
  );

  assign irq_o = |(stat_q & ctrl_q[NM-1:0]);

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_UP))        rdata_o = up_q;
    else if (addr_i == ADDR_W'(OFS_DOWN)) rdata_o = dn_q;
    else if (addr_i == ADDR_W'(OFS_CTRL)) rdata_o = DATA_W'(ctrl_q);
    else if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = DATA_W'(stat_q);
    else if (addr_i == ADDR_W'(OFS_KEY))  rdata_o = key_q;
    else begin
      for (int k = 0; k < NM; k++)
        if (addr_i == ADDR_W'(match_ofs(k))) rdata_o = match_q[k];
    end
  end

endmodule

// File: rtl/sec_alarm_timer_chk.sv
module sec_alarm_timer_chk
  import sec_alarm_pkg::*;
#(
  parameter int DATA_W = SA_DW,
  parameter int ADDR_W = SA_AW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_i,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic                 irq_o,
  input logic [DATA_W-1:0]    up_q,
  input logic [DATA_W-1:0]    dn_q,
  input logic [SA_CTRL_W-1:0] ctrl_q,
  input logic [1:0]           stat_q,
  input logic [1:0]           match_evt
);

  logic wr_up, wr_dn, wr_st;
  assign wr_up = wr_en_i && (addr_i == ADDR_W'(OFS_UP));
  assign wr_dn = wr_en_i && (addr_i == ADDR_W'(OFS_DOWN));
  assign wr_st = wr_en_i && (addr_i == ADDR_W'(OFS_STAT));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ctrl_q[CB_HOLD] && !ctrl_q[CB_SOFT_CLR] && !wr_up)
      |=> up_q == DATA_W'($past(up_q) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_HOLD] && !ctrl_q[CB_SOFT_CLR] && !wr_up && !wr_dn)
      |=> ($stable(up_q) && $stable(dn_q)));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_up && !ctrl_q[CB_SOFT_CLR]) |=> up_q == $past(wdata_i));

  p_hit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt[0] |=> stat_q[0]);

  p_hit1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt[1] |=> stat_q[1]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && wdata_i[0] && !match_evt[0]) |=> !stat_q[0]);

  p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q[0] && ctrl_q[0]) || (stat_q[1] && ctrl_q[1])) |-> irq_o);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 2'b00) |-> !irq_o);

  p_softclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_SOFT_CLR] |=> (up_q == '0 && dn_q == '1));

endmodule

bind sec_alarm_timer sec_alarm_timer_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .up_q      (up_q),
  .dn_q      (dn_q),
  .ctrl_q    (ctrl_q),
  .stat_q    (stat_q),
  .match_evt (match_evt)
);

// File: tb/sec_alarm_timer_test.sv
module sec_alarm_timer_test;

  localparam logic [7:0] A_UP = 8'h00, A_DN = 8'h04, A_M0 = 8'h08, A_M1 = 8'h0C;
  localparam logic [7:0] A_CT = 8'h10, A_ST = 8'h14, A_KY = 8'h18;
  localparam logic [31:0] MARK = 32'hB5C13F27;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read-compare, 2 tick count
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{2'd0, A_CT, 32'h40,        4'd3},   // R3 hold
    '{2'd0, A_UP, 32'd100,       4'd3},
    '{2'd2, 8'h0, 32'd3,         4'd3},
    '{2'd1, A_UP, 32'd100,       4'd3},   // R3 frozen
    '{2'd0, A_DN, 32'hFFFFFF9B,  4'd12},
    '{2'd0, A_CT, 32'h0,         4'd2},
    '{2'd2, 8'h0, 32'd3,         4'd2},
    '{2'd1, A_UP, 32'd103,       4'd2},   // R2
    '{2'd1, A_DN, 32'hFFFFFF98,  4'd2},   // R2
    '{2'd0, A_KY, MARK,          4'd10},
    '{2'd1, A_KY, MARK,          4'd10},  // R10
    '{2'd0, A_KY, 32'h12345678,  4'd10},
    '{2'd1, A_KY, 32'h12345678,  4'd10},
    '{2'd0, A_KY, MARK,          4'd10},
    '{2'd0, 8'h1C, 32'hDEADBEEF, 4'd11},  // R11 unmapped write
    '{2'd1, 8'h1C, 32'h0,        4'd11},
    '{2'd1, A_KY, MARK,          4'd11},
    '{2'd0, A_M1, 32'h777,       4'd12},  // R12 map
    '{2'd1, A_M1, 32'h777,       4'd12},
    '{2'd0, A_M1, 32'hFFFFFFFF,  4'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sec_alarm_timer uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input int req);
    addr_i = a;
    #2;
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL R%0d addr %h actual %h expected %h", req, a, rdata_o, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input int req);
    #1;
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL R%0d irq actual %b expected %b", req, irq_o, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state
    rd_chk(A_UP, 32'h0, 1);
    rd_chk(A_DN, 32'hFFFFFFFF, 1);
    rd_chk(A_M0, 32'hFFFFFFFF, 1);
    rd_chk(A_M1, 32'hFFFFFFFF, 1);
    rd_chk(A_CT, 32'h0, 1);
    rd_chk(A_ST, 32'h0, 1);
    rd_chk(A_KY, 32'h0, 1);
    irq_chk(1'b0, 1);

    for (int v = 0; v < NV; v++) begin
      case (TBL[v].kind)
        2'd0:    wr(TBL[v].addr, TBL[v].data);
        2'd1:    rd_chk(TBL[v].addr, TBL[v].data, int'(TBL[v].req));
        default: ticks(int'(TBL[v].data));
      endcase
    end

    // R11 control bit 5 reads zero
    wr(A_CT, 32'hFF);
    rd_chk(A_CT, 32'hDF, 11);
    wr(A_CT, 32'h0);

    // R9 soft clear holds counters and ignores ticks and writes
    wr(A_CT, 32'h10);
    ticks(2);
    wr(A_UP, 32'd55);
    rd_chk(A_UP, 32'h0, 9);
    rd_chk(A_DN, 32'hFFFFFFFF, 9);
    wr(A_CT, 32'h0);
    ticks(1);
    rd_chk(A_UP, 32'h1, 9);
    rd_chk(A_DN, 32'hFFFFFFFE, 9);

    // R5 write and tick in the same cycle
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = A_UP; wdata_i = 32'd500; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    rd_chk(A_UP, 32'd500, 5);
    rd_chk(A_DN, 32'hFFFFFFFD, 5);

    // R4 wrap; parking on all ones also hits the default match values
    wr(A_CT, 32'h40);
    wr(A_UP, 32'hFFFFFFFF);
    wr(A_DN, 32'h0);
    wr(A_CT, 32'h0);
    ticks(1);
    rd_chk(A_UP, 32'h0, 4);
    rd_chk(A_DN, 32'hFFFFFFFF, 4);
    rd_chk(A_ST, 32'h3, 6);
    irq_chk(1'b0, 8);
    wr(A_ST, 32'h3);
    rd_chk(A_ST, 32'h0, 7);

    // R6 R7 R8 match 0 path
    wr(A_CT, 32'h40);
    wr(A_UP, 32'd10);
    wr(A_M0, 32'd12);
    wr(A_CT, 32'h1);
    ticks(2);
    idle();
    rd_chk(A_ST, 32'h1, 6);
    irq_chk(1'b1, 8);
    wr(A_ST, 32'h0);
    rd_chk(A_ST, 32'h1, 7);
    wr(A_ST, 32'h1);
    rd_chk(A_ST, 32'h1, 7);   // R7 equality still true, bit set again
    wr(A_M0, 32'hFFFFFFFF);
    wr(A_ST, 32'h0);
    rd_chk(A_ST, 32'h1, 7);
    wr(A_ST, 32'h1);
    rd_chk(A_ST, 32'h0, 7);
    irq_chk(1'b0, 8);

    // R8 match 1 latches while disabled, then enable raises irq
    wr(A_M1, 32'd12);
    idle();
    rd_chk(A_ST, 32'h2, 6);
    irq_chk(1'b0, 8);
    wr(A_CT, 32'h3);
    irq_chk(1'b1, 8);
    wr(A_M1, 32'hFFFFFFFF);
    wr(A_ST, 32'h2);
    irq_chk(1'b0, 8);
    wr(A_CT, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule